// File: doc/BRIEF.md
# Virtual Interrupt Pending Composer

This block forms the four virtual-supervisor interrupt pending bits that a hypervisor-capable RISC-V hart shows in its machine-level and hypervisor-level pending views. It keeps a small software-written register of three virtual pending bits: software interrupt, timer interrupt and external interrupt. It combines that register with three live sources. The first is a per-guest external interrupt pending vector from the interrupt file, picked by a selector field of the hypervisor status word. The second is a platform external interrupt line. The third is a running comparison of adjusted time against a virtual timer compare value.

The software-interrupt bit can be written through three aliased register views: machine, hypervisor and virtual supervisor. Each view delivers a valid/data pair. The surrounding CSR logic guarantees that at most one of these pairs is valid in any cycle. The register also has a direct write port that loads all three bits.

All composed outputs are combinational from the current register state and the current inputs. Only the three register bits are clocked. They use a synchronous active-high reset.

Top module: `vs_irq_compose`

## Requirements
- R1: With `rst` high at a clock edge, all three register bits (`vip_q`) become 0, whatever writes are presented.
- R2: With `vip_we` high and no alias valid, a clock edge loads `vip_q` from `vip_wdata`. Bit 0 is the software bit, bit 1 the timer bit and bit 2 the external bit.
- R3: With exactly one alias valid (`m_ssip_vld`, `h_ssip_vld` or `s_ssip_vld`), a clock edge loads `vip_q[0]` from that view's data. This takes precedence over `vip_wdata[0]`. Bits 2:1 change only if `vip_we` is high.
- R4: With no write valid and `vip_we` low, `vip_q` keeps its value across a clock edge.
- R5: `vseip` is the OR of three terms: `vip_q[2]`, the guest pending bit chosen by the selector, and `plat_vseip`.
- R6: The selector is `hstat[17:12]`. A selector of 0, or any selector above GEILEN, chooses nothing, so that term is 0.
- R7: `vstip` is the OR of `vip_q[1]` and the result of an unsigned compare: (`now` + `tdelta`, taken modulo 2^64) >= `tcmp`.
- R8: `sgeip` is high exactly when some bit i in 1..GEILEN is set in both `gext_pend` and `gext_en`. Bit 0 of both vectors is treated as zero.
- R9: `vssip` always equals `vip_q[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vip_we | input | 1 | Direct write of the virtual pending register |
| vip_wdata | input | 3 | Write data {external, timer, software} |
| m_ssip_vld | input | 1 | Machine-view software-bit write valid |
| m_ssip_dat | input | 1 | Machine-view software-bit write data |
| h_ssip_vld | input | 1 | Hypervisor-view software-bit write valid |
| h_ssip_dat | input | 1 | Hypervisor-view software-bit write data |
| s_ssip_vld | input | 1 | Virtual-supervisor-view software-bit write valid |
| s_ssip_dat | input | 1 | Virtual-supervisor-view software-bit write data |
| gext_pend | input | GEILEN+1 | Per-guest external pending vector, bit 0 unused |
| gext_en | input | GEILEN+1 | Per-guest external enable vector, bit 0 unused |
| hstat | input | XW | Hypervisor status word, selector at 17:12 |
| plat_vseip | input | 1 | Platform virtual external interrupt line |
| now | input | XW | Current time |
| tdelta | input | XW | Time delta, two's complement |
| tcmp | input | XW | Virtual timer compare value |
| vip_q | output | 3 | Register bits {external, timer, software} |
| vseip | output | 1 | Composed virtual external pending |
| vstip | output | 1 | Composed virtual timer pending |
| sgeip | output | 1 | Guest external pending summary |
| vssip | output | 1 | Composed virtual software pending |

## Verification
The external bit is tried with random selectors across the full 6-bit range, including 0, GEILEN and GEILEN+1. These separate correct indexing from an off-by-one and from a selector that wraps into the vector. The timer compare is driven at equality, one below equality, a sum that wraps past 2^64 and a negative delta. These separate an unsigned, wrapping, inclusive compare from a signed or exclusive one. The summary bit is driven with only bit 0 set in both vectors, so a design that leaks bit 0 is caught. The alias writes are issued with `vip_we` high and carrying opposite data, which shows that the alias takes precedence.

// File: rtl/vs_irq_compose.sv
module vs_irq_compose #(
  parameter int GEILEN = 8,
  parameter int XW     = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vip_we,
  input  logic [2:0]      vip_wdata,
  input  logic            m_ssip_vld,
  input  logic            m_ssip_dat,
  input  logic            h_ssip_vld,
  input  logic            h_ssip_dat,
  input  logic            s_ssip_vld,
  input  logic            s_ssip_dat,
  input  logic [GEILEN:0] gext_pend,
  input  logic [GEILEN:0] gext_en,
  input  logic [XW-1:0]   hstat,
  input  logic            plat_vseip,
  input  logic [XW-1:0]   now,
  input  logic [XW-1:0]   tdelta,
  input  logic [XW-1:0]   tcmp,
  output logic [2:0]      vip_q,
  output logic            vseip,
  output logic            vstip,
  output logic            sgeip,
  output logic            vssip
);
  localparam int SELW = 6;
  localparam int SELL = 12;

  logic [SELW-1:0] sel;
  logic [GEILEN:0] gmask;
  logic            gsel_bit;
  logic            alias_any;
  logic            alias_dat;
  logic [XW-1:0]   vtime;

  assign sel       = hstat[SELL+SELW-1:SELL];
  assign gmask     = {{GEILEN{1'b1}}, 1'b0};
  assign alias_any = m_ssip_vld | h_ssip_vld | s_ssip_vld;
  assign alias_dat = (m_ssip_vld & m_ssip_dat) | (h_ssip_vld & h_ssip_dat) |
                     (s_ssip_vld & s_ssip_dat);

  always_comb begin
    gsel_bit = 1'b0;
    for (int i = 1; i <= GEILEN; i++)
      if (sel == SELW'(i)) gsel_bit = gext_pend[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vip_q <= '0;
    end else begin
      if (vip_we) vip_q[2:1] <= vip_wdata[2:1];
      if (alias_any)   vip_q[0] <= alias_dat;
      else if (vip_we) vip_q[0] <= vip_wdata[0];
    end
  end

  assign vtime = now + tdelta;
  assign vseip = vip_q[2] | gsel_bit | plat_vseip;
  assign vstip = vip_q[1] | (vtime >= tcmp);
  assign sgeip = |(gext_pend & gext_en & gmask);
  assign vssip = vip_q[0];
endmodule

module vs_irq_compose_chk #(
  parameter int GEILEN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            vip_we,
  input logic [2:0]      vip_wdata,
  input logic            m_ssip_vld,
  input logic            m_ssip_dat,
  input logic            h_ssip_vld,
  input logic            h_ssip_dat,
  input logic            s_ssip_vld,
  input logic            s_ssip_dat,
  input logic [GEILEN:0] gext_pend,
  input logic [GEILEN:0] gext_en,
  input logic [5:0]      sel,
  input logic            plat_vseip,
  input logic [2:0]      vip_q,
  input logic            vseip,
  input logic            vstip,
  input logic            sgeip,
  input logic            vssip
);
  // R3
  alias_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({m_ssip_vld, h_ssip_vld, s_ssip_vld}));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (vip_q == 3'b000));

  // R3
  m_alias_chk: assert property (@(posedge clk) disable iff (rst)
    m_ssip_vld |=> (vip_q[0] == $past(m_ssip_dat)));

  // R3
  h_alias_chk: assert property (@(posedge clk) disable iff (rst)
    h_ssip_vld |=> (vip_q[0] == $past(h_ssip_dat)));

  // R3
  s_alias_chk: assert property (@(posedge clk) disable iff (rst)
    s_ssip_vld |=> (vip_q[0] == $past(s_ssip_dat)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vip_we && !m_ssip_vld && !h_ssip_vld && !s_ssip_vld) |=> $stable(vip_q));

  // R5
  vseip_src_chk: assert property (@(posedge clk) disable iff (rst)
    (vip_q[2] || plat_vseip) |-> vseip);

  // R6
  sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((sel == 6'd0 || sel > 6'(GEILEN)) && !vip_q[2] && !plat_vseip) |-> !vseip);

  // R7
  vstip_reg_chk: assert property (@(posedge clk) disable iff (rst)
    vip_q[1] |-> vstip);

  // R8
  sgeip_none_chk: assert property (@(posedge clk) disable iff (rst)
    ((gext_pend[GEILEN:1] & gext_en[GEILEN:1]) == '0) |-> !sgeip);

  // R9
  vssip_chk: assert property (@(posedge clk) disable iff (rst)
    vssip == vip_q[0]);

  logic unused_ok;
  assign unused_ok = ^{vip_wdata, gext_pend[0], gext_en[0]};
endmodule

bind vs_irq_compose vs_irq_compose_chk #(.GEILEN(GEILEN)) u_chk (
  .clk(clk), .rst(rst), .vip_we(vip_we), .vip_wdata(vip_wdata),
  .m_ssip_vld(m_ssip_vld), .m_ssip_dat(m_ssip_dat),
  .h_ssip_vld(h_ssip_vld), .h_ssip_dat(h_ssip_dat),
  .s_ssip_vld(s_ssip_vld), .s_ssip_dat(s_ssip_dat),
  .gext_pend(gext_pend), .gext_en(gext_en), .sel(hstat[17:12]),
  .plat_vseip(plat_vseip), .vip_q(vip_q), .vseip(vseip), .vstip(vstip),
  .sgeip(sgeip), .vssip(vssip)
);

// File: tb/vs_irq_compose_test.sv
module vs_irq_compose_test;
  localparam int CLK_P  = 10;
  localparam int GEILEN = 8;
  localparam int XW     = 64;

  logic clk = 1'b0;
  logic rst;
  logic vip_we;
  logic [2:0] vip_wdata;
  logic m_ssip_vld, m_ssip_dat, h_ssip_vld, h_ssip_dat, s_ssip_vld, s_ssip_dat;
  logic [GEILEN:0] gext_pend, gext_en;
  logic [XW-1:0] hstat;
  logic plat_vseip;
  logic [XW-1:0] now, tdelta, tcmp;
  logic [2:0] vip_q;
  logic vseip, vstip, sgeip, vssip;

  int nchk = 0;
  int nfail = 0;
  logic [2:0] mq;

  always #(CLK_P/2) clk = ~clk;

  vs_irq_compose #(.GEILEN(GEILEN), .XW(XW)) uut (
    .clk(clk), .rst(rst), .vip_we(vip_we), .vip_wdata(vip_wdata),
    .m_ssip_vld(m_ssip_vld), .m_ssip_dat(m_ssip_dat),
    .h_ssip_vld(h_ssip_vld), .h_ssip_dat(h_ssip_dat),
    .s_ssip_vld(s_ssip_vld), .s_ssip_dat(s_ssip_dat),
    .gext_pend(gext_pend), .gext_en(gext_en), .hstat(hstat),
    .plat_vseip(plat_vseip), .now(now), .tdelta(tdelta), .tcmp(tcmp),
    .vip_q(vip_q), .vseip(vseip), .vstip(vstip), .sgeip(sgeip), .vssip(vssip)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic guest_bit(input logic [XW-1:0] hs, input logic [GEILEN:0] p);
    int s = int'(hs[17:12]);
    if (s == 0 || s > GEILEN) return 1'b0;
    return p[s];
  endfunction

  function automatic logic exp_vseip();
    return mq[2] | guest_bit(hstat, gext_pend) | plat_vseip;
  endfunction

  function automatic logic exp_vstip();
    logic [XW-1:0] t = now + tdelta;
    return mq[1] | (t >= tcmp);
  endfunction

  function automatic logic exp_sgeip();
    for (int i = 1; i <= GEILEN; i++)
      if (gext_pend[i] && gext_en[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [2:0] next_q();
    logic [2:0] n = mq;
    if (vip_we) n = vip_wdata;
    if (m_ssip_vld) n[0] = m_ssip_dat;
    else if (h_ssip_vld) n[0] = h_ssip_dat;
    else if (s_ssip_vld) n[0] = s_ssip_dat;
    return n;
  endfunction

  task automatic idle_inputs();
    vip_we = 0; vip_wdata = 0;
    m_ssip_vld = 0; m_ssip_dat = 0; h_ssip_vld = 0; h_ssip_dat = 0;
    s_ssip_vld = 0; s_ssip_dat = 0;
    gext_pend = 0; gext_en = 0; hstat = 0; plat_vseip = 0;
    now = 0; tdelta = 0; tcmp = 64'hFFFF_FFFF_FFFF_FFFF;
  endtask

  // inputs are already driven; check combinational outputs, then clock once
  task automatic settle_and_step();
    #1;
    chk("R5", vseip, exp_vseip());
    chk("R7", vstip, exp_vstip());
    chk("R8", sgeip, exp_sgeip());
    chk("R9", vssip, mq[0]);
    mq = next_q();
    @(negedge clk);
    chk("R2/R3/R4 state", vip_q, mq);
  endtask

  task automatic set_sel(input int s);
    hstat[17:12] = 6'(s);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        #(CLK_P * 200000);
        if (!done) begin
          nchk++; nfail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
          $finish;
        end
      end
    join_none

    void'($urandom(32'h5EED_1234));
    idle_inputs();
    rst = 1; vip_we = 1; vip_wdata = 3'b111; m_ssip_vld = 1; m_ssip_dat = 1;
    @(negedge clk); @(negedge clk);
    chk("R1 reset", vip_q, 3'b000);
    mq = 0;
    rst = 0; idle_inputs();
    @(negedge clk);
    chk("R1 after release", vip_q, 3'b000);

    // R2 direct write
    vip_we = 1; vip_wdata = 3'b101;
    settle_and_step();
    chk("R2 direct", vip_q, 3'b101);
    // R4 hold
    idle_inputs();
    settle_and_step();
    chk("R4 hold", vip_q, 3'b101);
    // R3 alias precedence over direct write
    vip_we = 1; vip_wdata = 3'b010; h_ssip_vld = 1; h_ssip_dat = 1;
    settle_and_step();
    chk("R3 alias wins", vip_q, 3'b011);
    idle_inputs(); s_ssip_vld = 1; s_ssip_dat = 0;
    settle_and_step();
    chk("R3 vs view", vip_q, 3'b010);
    idle_inputs(); m_ssip_vld = 1; m_ssip_dat = 1;
    settle_and_step();
    chk("R3 m view", vip_q, 3'b011);
    idle_inputs(); vip_we = 1; vip_wdata = 3'b000;
    settle_and_step();

    // R6 selector corners
    idle_inputs(); gext_pend = '1;
    set_sel(0); #1; chk("R6 sel 0", vseip, 1'b0);
    set_sel(GEILEN); #1; chk("R6 sel GEILEN", vseip, 1'b1);
    set_sel(GEILEN + 1); #1; chk("R6 sel GEILEN+1", vseip, 1'b0);
    set_sel(63); #1; chk("R6 sel 63", vseip, 1'b0);
    gext_pend = 9'b0_0000_1000; set_sel(3); #1; chk("R6 sel 3", vseip, 1'b1);
    set_sel(2); #1; chk("R6 sel 2", vseip, 1'b0);
    plat_vseip = 1; #1; chk("R5 platform", vseip, 1'b1);

    // R8 bit 0 ignored
    idle_inputs(); gext_pend = 9'h001; gext_en = 9'h001; #1;
    chk("R8 bit0", sgeip, 1'b0);
    gext_pend = 9'h100; gext_en = 9'h100; #1;
    chk("R8 top bit", sgeip, 1'b1);
    gext_en = 9'h0FF; #1;
    chk("R8 disjoint", sgeip, 1'b0);

    // R7 timer corners
    idle_inputs();
    now = 64'd100; tdelta = 64'd0; tcmp = 64'd100; #1; chk("R7 equal", vstip, 1'b1);
    tcmp = 64'd101; #1; chk("R7 below", vstip, 1'b0);
    now = '1; tdelta = 64'd1; tcmp = 64'd0; #1; chk("R7 wrap ge", vstip, 1'b1);
    tcmp = 64'd1; #1; chk("R7 wrap lt", vstip, 1'b0);
    now = 64'd50; tdelta = -64'sd10; tcmp = 64'd40; #1; chk("R7 neg delta eq", vstip, 1'b1);
    tcmp = 64'd41; #1; chk("R7 neg delta lt", vstip, 1'b0);
    now = 64'h8000_0000_0000_0000; tdelta = 0; tcmp = 64'h7FFF_FFFF_FFFF_FFFF; #1;
    chk("R7 unsigned", vstip, 1'b1);
    @(negedge clk);

    // random phase
    for (int it = 0; it < 2000; it++) begin
      int pick;
      idle_inputs();
      vip_we = ($urandom % 4) == 0;
      vip_wdata = 3'($urandom);
      pick = $urandom % 6;
      if (pick == 0) begin m_ssip_vld = 1; m_ssip_dat = 1'($urandom); end
      if (pick == 1) begin h_ssip_vld = 1; h_ssip_dat = 1'($urandom); end
      if (pick == 2) begin s_ssip_vld = 1; s_ssip_dat = 1'($urandom); end
      gext_pend = (GEILEN+1)'($urandom);
      gext_en = (GEILEN+1)'($urandom & $urandom);
      hstat = {$urandom, $urandom};
      plat_vseip = ($urandom % 8) == 0;
      now = {$urandom, $urandom};
      tdelta = ($urandom % 2) ? 64'($signed($urandom % 64) - 32) : {$urandom, $urandom};
      tcmp = ($urandom % 2) ? now + tdelta + 64'($signed($urandom % 5) - 2) : {$urandom, $urandom};
      settle_and_step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule